// File: doc/BRIEF.md
# DMA Channel Request and Bus-Mode Sequencer

This block is the control core of one DMA channel. Software arms it with a unit count and a unit size. The block then waits for an activation request from one of three sources: a free-running automatic request, a level request from an on-chip peripheral, or an active-low request pin. It runs a bus request/grant handshake toward a memory-side transfer engine. The engine moves one unit per `unit_start` pulse and acknowledges each unit with `unit_done`.

The pin source can be set to trigger on a falling edge or on a low level. The pin always passes through a synchronizer first. In edge mode, a captured request stays pending until the bus is granted for it. Bus access is either cycle stealing or burst. In cycle stealing, the bus is dropped after every unit. In burst, the bus is held until the count runs out. Burst is only possible with the automatic source. A stub input that flags another channel's pending request forces the bus to be released at the next unit boundary. When the count reaches zero, the channel disables itself and emits a one-cycle done pulse. A pin-sourced request combined with a peripheral-to-peripheral transfer is an illegal configuration. It raises an error and never activates.

Top module: `dma_seq_core`

## Requirements
- R1: No bus request is raised while `chan_enable` is 0. `enable_set` loads `cfg_count` and sets `chan_enable` only when `cfg_count` is nonzero. With a zero count, `enable_set` is ignored.
- R2: With `cfg_ext_level`=0 (falling-edge mode), each falling edge of `ext_req_n` produces exactly one unit, even if the pin is held low. A captured edge stays pending while the grant is withheld.
- R3: With `cfg_ext_level`=1 (low-level mode), units keep being requested while `ext_req_n` is low. Once the pin returns high, no further bus request occurs.
- R4: `cfg_src` encodes 0 = automatic (requests whenever enabled), 1 = peripheral (requests while `irq_req`=1, and the pin is ignored), 2 = pin. Value 3 is reserved and treated as illegal.
- R5: Burst mode applies only when `cfg_src`=0 and `cfg_burst`=1. The peripheral and pin sources always use cycle stealing, even with `cfg_burst`=1.
- R6: In cycle-stealing mode, `bus_req` is 0 in the cycle after each `unit_done`, so an N-unit run releases the bus N times.
- R7: In burst mode, `bus_req` stays high from the first grant through the last `unit_done`. The next `unit_start` comes in the cycle after each non-final `unit_done`.
- R8: If `other_pending`=1 when a unit completes, `bus_req` is 0 in the next cycle, even in burst mode. The remaining units are requested again afterwards.
- R9: Each `unit_done` decrements `units_left`. When the last unit completes, `xfer_done` pulses for exactly one cycle, `chan_enable` clears and `units_left` is 0.
- R10: `cfg_err` is 1 when `cfg_src`=2 with `cfg_p2p`=1, or when `cfg_src`=3. While it is 1, no bus request is raised.
- R11: `unit_size` carries the size latched at `enable_set` (0 byte, 1 word, 2 longword, 3 block) and is valid with every `unit_start`.
- R12: After reset, `bus_req`, `unit_start`, `chan_enable`, `xfer_done` and `units_left` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_set | input | 1 | Arm pulse: loads count and size, sets enable |
| cfg_count | input | CNT_W | Number of units to transfer |
| cfg_unit | input | 2 | Unit size code |
| cfg_src | input | 2 | Activation source code |
| cfg_burst | input | 1 | Burst request (automatic source only) |
| cfg_ext_level | input | 1 | 1 = low-level, 0 = falling-edge pin detection |
| cfg_p2p | input | 1 | Transfer is peripheral-to-peripheral |
| irq_req | input | 1 | Peripheral interrupt request |
| ext_req_n | input | 1 | Asynchronous active-low request pin |
| other_pending | input | 1 | Another channel wants the bus |
| bus_grant | input | 1 | Bus granted by the engine |
| unit_done | input | 1 | Engine finished the current unit |
| bus_req | output | 1 | Bus request |
| unit_start | output | 1 | One-cycle pulse: move one unit |
| unit_size | output | 2 | Size of the unit to move |
| chan_enable | output | 1 | Channel armed |
| xfer_done | output | 1 | One-cycle end-of-transfer pulse |
| cfg_err | output | 1 | Illegal configuration |
| units_left | output | CNT_W | Units remaining |

## Verification
Some behaviours are checked by assertions on every cycle. These are: the bus drop after a unit in stealing mode or under preemption, the back-to-back restart inside a burst, the counter stepping down by one per completion, edge capture into the pending flag, the single-cycle done pulse with the enable cleared, and the absence of a bus request while disabled or misconfigured. Other behaviours only show up across a whole scenario, so only the bench can demonstrate them. These are: how many times the bus is released per run, that a held-low pin in edge mode yields a single unit, that a withheld grant does not lose a captured edge, that the peripheral source ignores the pin, and that level mode stops once the pin is released.

// File: rtl/dma_seq_pkg.sv
// Package: shared encodings for the DMA channel sequencer.
// Assumes: source and state codes are used consistently by all sub-blocks.
package dma_seq_pkg;

    typedef enum logic [1:0] {
        SRC_AUTO = 2'd0,
        SRC_IRQ  = 2'd1,
        SRC_PIN  = 2'd2,
        SRC_RSVD = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        BS_IDLE = 2'd0,
        BS_REQ  = 2'd1,
        BS_XFER = 2'd2,
        BS_REL  = 2'd3
    } bus_st_e;

endpackage

// File: rtl/dma_req_detect.sv
// Module: pin request detector.
// Synchronizes the active-low request pin through SYNC_STAGES flops. It then
// reports a request either while the synchronized pin is low (level mode) or
// from a pending flag set on each falling edge (edge mode).
// Assumes: clear_pending marks the cycle the request was serviced.
// If a set and a clear fall in the same cycle, the set wins.
module dma_req_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic level_mode,
    input  logic clear_pending,
    output logic pin_active
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pending_q;
    logic                   pin_sync;
    logic                   fall_det;

    assign pin_sync = sync_q[SYNC_STAGES-1];
    assign fall_det = prev_q & ~pin_sync;

    // Synchronizer chain, idle level is high.
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b1;
                else        sync_q[i] <= (i == 0) ? pin_n : sync_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    // Delay stage used for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_sync;
    end

    // Pending flag: captured edge held until serviced.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pending_q <= 1'b0;
        else if (!level_mode && fall_det) pending_q <= 1'b1;
        else if (clear_pending || level_mode) pending_q <= 1'b0;
    end

    assign pin_active = level_mode ? ~pin_sync : pending_q;

    // Edge capture must land in the pending flag.
    assert_edge_captured_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && fall_det) |=> pending_q);

endmodule

// File: rtl/dma_unit_counter.sv
// Module: remaining-unit counter.
// Loads a count on arm and steps down by one per completed unit.
// Assumes: dec is asserted only while the count is nonzero.
module dma_unit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             is_last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Count register: load has priority over decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (load)                  cnt <= load_val;
        else if (dec && cnt != '0)      cnt <= cnt - ONE;
    end

    assign is_last = (cnt == ONE);

    // Each completion removes exactly one unit.
    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && cnt != '0) |=> (cnt == $past(cnt) - ONE));

endmodule

// File: rtl/dma_bus_fsm.sv
// Module: bus handshake sequencer.
// Raises the bus request on activation and issues one unit_start per grant.
// Releases the bus after each unit (stealing), or keeps it through the run
// (burst) unless another channel is pending.
// Assumes: the grant stays high while the request is held.
module dma_bus_fsm
    import dma_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic burst_mode,
    input  logic bus_grant,
    input  logic unit_done,
    input  logic other_pending,
    input  logic is_last,
    output logic bus_req,
    output logic unit_start,
    output logic dec,
    output logic last_done,
    output logic serviced
);
    bus_st_e state_q;
    logic    start_q;

    assign dec       = (state_q == BS_XFER) && unit_done;
    assign last_done = dec && is_last;
    assign serviced  = (state_q == BS_REQ) && bus_grant;
    assign bus_req   = (state_q == BS_REQ) || (state_q == BS_XFER);
    assign unit_start = start_q;

    // State register and start pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BS_IDLE;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state_q)
                BS_IDLE: if (go) state_q <= BS_REQ;
                BS_REQ: if (bus_grant) begin
                    state_q <= BS_XFER;
                    start_q <= 1'b1;
                end
                BS_XFER: if (unit_done) begin
                    if (!is_last && burst_mode && !other_pending) start_q <= 1'b1;
                    else                                         state_q <= BS_REL;
                end
                default: state_q <= BS_IDLE;
            endcase
        end
    end

    // Stealing mode drops the bus after every unit.
    assert_steal_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !burst_mode) |=> !bus_req);

    // Burst mode restarts immediately with the bus still held.
    assert_burst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && burst_mode && !other_pending && !is_last) |=> (bus_req && unit_start));

    // Another channel pending forces a release at the unit boundary.
    assert_preempt_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && other_pending) |=> !bus_req);

endmodule

// File: rtl/dma_seq_core.sv
// Module: DMA channel request and bus-mode sequencer (top).
// Selects the activation source, derives the bus-access mode, flags illegal
// configurations, and ties the detector, counter and bus FSM together.
// Assumes: configuration inputs are stable while the channel is armed.
module dma_seq_core
    import dma_seq_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_set,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [1:0]       cfg_unit,
    input  logic [1:0]       cfg_src,
    input  logic             cfg_burst,
    input  logic             cfg_ext_level,
    input  logic             cfg_p2p,
    input  logic             irq_req,
    input  logic             ext_req_n,
    input  logic             other_pending,
    input  logic             bus_grant,
    input  logic             unit_done,
    output logic             bus_req,
    output logic             unit_start,
    output logic [1:0]       unit_size,
    output logic             chan_enable,
    output logic             xfer_done,
    output logic             cfg_err,
    output logic [CNT_W-1:0] units_left
);
    src_e src;
    logic pin_active;
    logic src_req;
    logic go;
    logic burst_mode;
    logic arm;
    logic dec;
    logic last_done;
    logic serviced;
    logic is_last;
    logic en_q;
    logic done_q;
    logic [1:0] size_q;

    assign src        = src_e'(cfg_src);
    assign cfg_err    = (src == SRC_RSVD) || ((src == SRC_PIN) && cfg_p2p);
    assign burst_mode = (src == SRC_AUTO) && cfg_burst;
    assign arm        = enable_set && (cfg_count != '0) && !en_q;

    // Activation request from the selected source.
    always_comb begin
        case (src)
            SRC_AUTO: src_req = 1'b1;
            SRC_IRQ:  src_req = irq_req;
            SRC_PIN:  src_req = pin_active;
            default:  src_req = 1'b0;
        endcase
    end

    assign go = en_q && !cfg_err && src_req;

    // Channel enable: set on a valid arm, cleared on the final unit.
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= 1'b0;
        else if (last_done) en_q <= 1'b0;
        else if (arm)       en_q <= 1'b1;
    end

    // End-of-run pulse, registered from the final completion.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= last_done;
    end

    // Unit size latched at arm time.
    always_ff @(posedge clk) begin
        if (!rst_n)   size_q <= 2'd0;
        else if (arm) size_q <= cfg_unit;
    end

    dma_req_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_n        (ext_req_n),
        .level_mode   (cfg_ext_level),
        .clear_pending(serviced && (src == SRC_PIN)),
        .pin_active   (pin_active)
    );

    dma_unit_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (arm),
        .load_val(cfg_count),
        .dec     (dec),
        .cnt     (units_left),
        .is_last (is_last)
    );

    dma_bus_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (go),
        .burst_mode   (burst_mode),
        .bus_grant    (bus_grant),
        .unit_done    (unit_done),
        .other_pending(other_pending),
        .is_last      (is_last),
        .bus_req      (bus_req),
        .unit_start   (unit_start),
        .dec          (dec),
        .last_done    (last_done),
        .serviced     (serviced)
    );

    assign chan_enable = en_q;
    assign xfer_done   = done_q;
    assign unit_size   = size_q;

    // A new bus request needs the channel armed.
    assert_no_req_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(en_q));

    // An illegal configuration never starts a request.
    assert_err_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !bus_req) |=> !bus_req);

    // Done is a single-cycle pulse with the channel disarmed.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (!en_q ##1 !xfer_done));

endmodule

// File: tb/dma_seq_core_tb.sv
module dma_seq_core_tb;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable_set = 1'b0;
    logic [CNT_W-1:0] cfg_count = '0;
    logic [1:0]       cfg_unit = 2'd0;
    logic [1:0]       cfg_src = 2'd0;
    logic             cfg_burst = 1'b0;
    logic             cfg_ext_level = 1'b0;
    logic             cfg_p2p = 1'b0;
    logic             irq_req = 1'b0;
    logic             ext_req_n = 1'b1;
    logic             other_pending = 1'b0;
    logic             bus_grant = 1'b0;
    logic             unit_done = 1'b0;
    logic             bus_req;
    logic             unit_start;
    logic [1:0]       unit_size;
    logic             chan_enable;
    logic             xfer_done;
    logic             cfg_err;
    logic [CNT_W-1:0] units_left;

    int vectors = 0;
    int miscompares = 0;
    int n_starts, n_falls, n_done, timer;
    logic grant_en = 1'b1;
    logic prev_req, prev_done, done_wide, size_bad;

    dma_seq_core #(.CNT_W(CNT_W)) u_dut (.*);

    always #5 clk = ~clk;

    // Transfer-engine model and monitors, all on the falling edge.
    always @(negedge clk) begin
        unit_done = 1'b0;
        if (timer == 1) unit_done = 1'b1;
        if (timer > 0) timer--;
        if (unit_start) begin
            timer = 2;
            n_starts++;
            if (unit_size !== cfg_unit) size_bad = 1'b1;
        end
        bus_grant = bus_req && grant_en;
        if (prev_req && !bus_req) n_falls++;
        prev_req = bus_req;
        if (xfer_done) n_done++;
        if (xfer_done && prev_done) done_wide = 1'b1;
        prev_done = xfer_done;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(negedge clk);
        miscompares++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        n_starts = 0; n_falls = 0; n_done = 0;
        done_wide = 1'b0; size_bad = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ext_req_n = 1'b1; irq_req = 1'b0; other_pending = 1'b0;
        grant_en = 1'b1; cfg_p2p = 1'b0; cfg_burst = 1'b0; timer = 0;
        prev_req = 1'b0; prev_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        clear_stats();
    endtask

    task automatic arm(input int count);
        @(negedge clk);
        cfg_count = CNT_W'(count); enable_set = 1'b1;
        @(negedge clk);
        enable_set = 1'b0;
    endtask

    task automatic wait_end(input int limit);
        for (int i = 0; i < limit && chan_enable; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(!bus_req && !unit_start && !chan_enable && !xfer_done && units_left == 0,
              "R12 reset", int'(bus_req) + int'(chan_enable) + int'(units_left), 0);
    endtask

    task automatic t_enable_gate();
        do_reset();
        cfg_src = 2'd0;
        repeat (10) @(negedge clk);
        check(n_falls == 0 && !bus_req, "R1 disabled no req", int'(bus_req), 0);
        arm(0);
        repeat (10) @(negedge clk);
        check(!chan_enable && !bus_req, "R1 zero count ignored", int'(chan_enable), 0);
    endtask

    task automatic t_steal_auto();
        do_reset();
        cfg_src = 2'd0; cfg_burst = 1'b0; cfg_unit = 2'd1;
        arm(3);
        wait_end(200);
        check(n_starts == 3, "R9 three units", n_starts, 3);
        check(n_falls == 3, "R6 release per unit", n_falls, 3);
        check(n_done == 1 && !done_wide, "R9 single done pulse", n_done, 1);
        check(!chan_enable && units_left == 0, "R9 disarm at zero", int'(units_left), 0);
        check(!size_bad, "R11 size word", int'(unit_size), 1);
    endtask

    task automatic t_burst_auto();
        do_reset();
        cfg_src = 2'd0; cfg_burst = 1'b1; cfg_unit = 2'd3;
        arm(4);
        wait_end(200);
        check(n_starts == 4, "R7 burst units", n_starts, 4);
        check(n_falls == 1, "R7 bus held through burst", n_falls, 1);
        check(!size_bad, "R11 size block", int'(unit_size), 3);
    endtask

    task automatic t_preempt();
        do_reset();
        cfg_src = 2'd0; cfg_burst = 1'b1; other_pending = 1'b1;
        arm(4);
        wait_end(300);
        check(n_falls == 4, "R8 release on other pending", n_falls, 4);
        check(n_starts == 4 && n_done == 1, "R8 all units served", n_starts, 4);
    endtask

    task automatic t_irq_source();
        do_reset();
        cfg_src = 2'd1; cfg_burst = 1'b1; cfg_ext_level = 1'b1; ext_req_n = 1'b0;
        arm(3);
        repeat (20) @(negedge clk);
        check(n_starts == 0 && !bus_req, "R4 irq source ignores pin", n_starts, 0);
        ext_req_n = 1'b1; irq_req = 1'b1;
        wait_end(300);
        check(n_starts == 3, "R4 irq drives units", n_starts, 3);
        check(n_falls == 3, "R5 irq forces stealing", n_falls, 3);
    endtask

    task automatic t_edge();
        do_reset();
        cfg_src = 2'd2; cfg_ext_level = 1'b0;
        arm(3);
        ext_req_n = 1'b0;
        repeat (40) @(negedge clk);
        check(n_starts == 1 && units_left == 2, "R2 held-low edge gives one unit", n_starts, 1);
        ext_req_n = 1'b1;
        grant_en = 1'b0;
        repeat (4) @(negedge clk);
        ext_req_n = 1'b0;
        repeat (3) @(negedge clk);
        ext_req_n = 1'b1;
        repeat (20) @(negedge clk);
        check(n_starts == 1 && bus_req, "R2 request waits for grant", n_starts, 1);
        grant_en = 1'b1;
        repeat (20) @(negedge clk);
        check(n_starts == 2 && units_left == 1, "R2 pending edge served once", n_starts, 2);
    endtask

    task automatic t_level();
        do_reset();
        cfg_src = 2'd2; cfg_ext_level = 1'b1;
        arm(6);
        ext_req_n = 1'b0;
        for (int i = 0; i < 200 && n_starts < 2; i++) @(negedge clk);
        ext_req_n = 1'b1;
        repeat (30) @(negedge clk);
        check(n_starts >= 2 && n_starts <= 4, "R3 level repeats units", n_starts, 2);
        check(!bus_req && chan_enable && units_left != 0, "R3 pin high stops", int'(bus_req), 0);
        begin
            int s0 = n_starts;
            repeat (30) @(negedge clk);
            check(n_starts == s0, "R3 no further requests", n_starts, s0);
        end
    endtask

    task automatic t_illegal();
        do_reset();
        cfg_src = 2'd2; cfg_p2p = 1'b1; cfg_ext_level = 1'b1; ext_req_n = 1'b0;
        arm(2);
        repeat (30) @(negedge clk);
        check(cfg_err && n_starts == 0 && !bus_req, "R10 pin+p2p blocked", n_starts, 0);
        cfg_src = 2'd3; cfg_p2p = 1'b0;
        repeat (30) @(negedge clk);
        check(cfg_err && n_starts == 0 && !bus_req, "R10 reserved src blocked", n_starts, 0);
        cfg_src = 2'd0; ext_req_n = 1'b1;
        wait_end(200);
        check(!cfg_err && n_starts == 2, "R10 legal config runs", n_starts, 2);
    endtask

    initial begin
        t_reset();
        t_enable_gate();
        t_steal_auto();
        t_burst_auto();
        t_preempt();
        t_irq_source();
        t_edge();
        t_level();
        t_illegal();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule